// File: doc/BRIEF.md
# Evaluation Stack with Overflow and Underflow Traps

This block holds the operand stack of a bytecode interpreter: eight 16-bit cells kept in flops, plus a pointer that counts how many cells are occupied. A pointer of 0 means the stack is empty and a pointer of 8 means it is full. Cell k (counting from 0) holds the value pushed when the pointer went from k to k+1. The opcode decoder drives one command at a time. Each command can be a push, a pop, a pop into memory, a two-word load that pushes two words, a two-word store that pops two words, or an indexed load that reads memory at top-of-stack plus an offset and pushes the result.

Any command that would go past either end of the stack is refused. The block leaves the stack exactly as it was and sends a one-cycle trap code to the handler logic. Memory is reached through a registered request port: request, write enable, address and write data. Read data comes back one clock after the request is seen. Commands that need more than one memory access raise `busy`, and the block drops any command presented while `busy` is high.

Top module: `eval_stack`

## Requirements
- R1: After reset `depth` is 0, `top_data` is 0, `trap_code` is 0, and both `busy` and `mem_req` are low.
- R2: A push (`cmd_op` = 1) with depth below 8 stores `cmd_data` in the cell above the top and raises `depth` by one. `top_data` always shows the newest live value, so values leave in last-in-first-out order.
- R3: A push at depth 8 writes no cell. `depth` stays at 8, `top_data` is unchanged, and `trap_code` pulses 1 (overflow).
- R4: A pop (`cmd_op` = 2) with depth of at least 1 puts the removed value on `pop_data` and raises `pop_valid` in the same cycle that `depth` drops by one.
- R5: A pop or a store at depth 0 leaves the stack untouched and pulses `trap_code` = 2 (underflow).
- R6: A store (`cmd_op` = 3) removes the top value and issues one memory write of that value to `cmd_addr`.
- R7: A double push (`cmd_op` = 4) reads address A = `cmd_addr` + `cmd_data` and then A+1. It pushes the word from A first and the word from A+1 second, and ends with `depth` two higher. `busy` is high from the cycle after acceptance until the second push.
- R8: A double push at a depth above 6 pulses overflow (code 1), issues no memory request and leaves `depth` unchanged.
- R9: A double pop (`cmd_op` = 5) writes the cell below the top to A = `cmd_addr` + `cmd_data` first, then writes the top cell to A+1, and lowers `depth` by two.
- R10: A double pop at a depth below 2 pulses underflow (code 2) and leaves `depth` and `top_data` unchanged.
- R11: An indexed load (`cmd_op` = 6) reads memory at top value + `cmd_data` and pushes the word read. At depth 0 it pulses underflow; at depth 8 it pulses overflow.
- R12: `trap_code` uses only 0 (none), 1 (overflow) and 2 (underflow). It lasts one cycle per refused command, and `depth` does not change in a cycle where a trap is shown.
- R13: A command presented while `busy` is high has no effect on the stack, and no trap is raised while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (1 push, 2 pop, 3 store, 4 double push, 5 double pop, 6 indexed load) |
| cmd_data | input | 16 | Push value or address offset |
| cmd_addr | input | 16 | Store address or base address |
| busy | output | 1 | Multi-cycle command in progress; commands are dropped |
| depth | output | 4 | Number of occupied cells, 0 to 8 |
| top_data | output | 16 | Value at top of stack, 0 when empty |
| pop_data | output | 16 | Value removed by the last pop |
| pop_valid | output | 1 | One-cycle strobe qualifying `pop_data` |
| trap_code | output | 2 | One-cycle trap: 0 none, 1 overflow, 2 underflow |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after the request is seen |

## Verification
Several checks run on every cycle: the pointer never goes above 8, no trap code outside the three defined values ever appears, and no trap coincides with a pointer change or with `busy`. Each `pop_valid` strobe also lines up with a drop of exactly one in the pointer. The directed scenarios cover what those checks cannot see: the order of the two memory accesses and of the two pushes in double transfers, the address arithmetic, LIFO data order, and a command arriving during `busy` being dropped.

// File: rtl/estk_pkg.sv
// Shared types for the evaluation stack: command codes, trap codes and
// controller states. Command and trap encodings are part of the port contract.
package estk_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_STORE = 3'd3,
        OP_DPUSH = 3'd4,
        OP_DPOP  = 3'd5,
        OP_IDXRD = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        TRAP_NONE  = 2'd0,
        TRAP_OVER  = 2'd1,
        TRAP_UNDER = 2'd2
    } trap_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DL_REQ,
        ST_DL_LO,
        ST_DL_HI,
        ST_DP_HI,
        ST_IX_REQ,
        ST_IX_CAP
    } state_e;
endpackage

// File: rtl/estk_regfile.sv
// Flop-based cell array of the stack. One write port and two read ports
// (top and the cell below it). Assumes the caller never writes a cell
// index at or beyond DEPTH.
module estk_regfile #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx_top,
    input  logic [IDX_W-1:0]  ridx_next,
    output logic [DATA_W-1:0] rd_top,
    output logic [DATA_W-1:0] rd_next
);
    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Cell g: cleared on reset, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[g] <= '0;
            else if (we && widx == IDX_W'(g))
                cells[g] <= wdata;
        end
    end

    // Read ports: plain array selects.
    always_comb begin
        rd_top  = cells[ridx_top];
        rd_next = cells[ridx_next];
    end
endmodule

// File: rtl/estk_guard.sv
// Bounds check for one command: compares the cells it would remove and add
// against the current pointer. Underflow takes priority over overflow.
module estk_guard #(
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  estk_pkg::op_e     op,
    input  logic [PTR_W-1:0]  sp,
    output estk_pkg::trap_e   trap
);
    import estk_pkg::*;
    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

    logic [PTR_W-1:0] need_out;
    logic [PTR_W-1:0] need_in;
    logic [PTR_W-1:0] room;

    // Classify the command by how many cells it consumes and produces.
    always_comb begin
        need_out = '0;
        need_in  = '0;
        case (op)
            OP_PUSH:  need_in  = PTR_W'(1);
            OP_POP:   need_out = PTR_W'(1);
            OP_STORE: need_out = PTR_W'(1);
            OP_DPUSH: need_in  = PTR_W'(2);
            OP_DPOP:  need_out = PTR_W'(2);
            OP_IDXRD: begin
                need_out = PTR_W'(1);
                need_in  = PTR_W'(1);
            end
            default: ;
        endcase
        room = FULL - sp;
        if (sp < need_out)
            trap = TRAP_UNDER;
        else if (room < need_in)
            trap = TRAP_OVER;
        else
            trap = TRAP_NONE;
    end
endmodule

// File: rtl/estk_ctrl.sv
// Command sequencer: owns the pointer, the memory request registers, the pop
// strobe and the trap pulse. Assumes memory returns read data one cycle after
// it samples a read request. Multi-cycle commands hold busy until done.
module estk_ctrl #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  estk_pkg::op_e     cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  estk_pkg::trap_e   trap_c,
    input  logic [DATA_W-1:0] rd_top,
    input  logic [DATA_W-1:0] rd_next,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PTR_W-1:0]  sp,
    output logic              busy,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_widx,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [IDX_W-1:0]  ridx_top,
    output logic [IDX_W-1:0]  ridx_next,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output estk_pkg::trap_e   trap_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    import estk_pkg::*;

    state_e            state;
    logic [ADDR_W-1:0] base_q;
    logic              accept;
    logic              go;
    logic [ADDR_W-1:0] sum_addr;

    // Acceptance and shared address arithmetic.
    always_comb begin
        accept    = cmd_valid && state == ST_IDLE && cmd_op != OP_NOP;
        go        = accept && trap_c == TRAP_NONE;
        sum_addr  = cmd_addr + ADDR_W'(cmd_data);
        busy      = state != ST_IDLE;
        ridx_top  = IDX_W'(sp - PTR_W'(1));
        ridx_next = IDX_W'(sp - PTR_W'(2));
    end

    // Cell write port: a direct push, or memory data landing on the stack.
    always_comb begin
        rf_widx  = IDX_W'(sp);
        rf_wdata = mem_rdata;
        rf_we    = 1'b0;
        if (state == ST_IDLE && go && cmd_op == OP_PUSH) begin
            rf_we    = 1'b1;
            rf_wdata = cmd_data;
        end else if (state == ST_DL_LO || state == ST_DL_HI || state == ST_IX_CAP) begin
            rf_we = 1'b1;
        end
    end

    // Sequencer: pointer, state, strobes and memory request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sp        <= '0;
            base_q    <= '0;
            pop_data  <= '0;
            pop_valid <= 1'b0;
            trap_q    <= TRAP_NONE;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            pop_valid <= 1'b0;
            trap_q    <= TRAP_NONE;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept && trap_c != TRAP_NONE) begin
                        trap_q <= trap_c;
                    end else if (go) begin
                        case (cmd_op)
                            OP_PUSH: sp <= sp + PTR_W'(1);
                            OP_POP: begin
                                pop_data  <= rd_top;
                                pop_valid <= 1'b1;
                                sp        <= sp - PTR_W'(1);
                            end
                            OP_STORE: begin
                                mem_req   <= 1'b1;
                                mem_we    <= 1'b1;
                                mem_addr  <= cmd_addr;
                                mem_wdata <= rd_top;
                                sp        <= sp - PTR_W'(1);
                            end
                            OP_DPUSH: begin
                                mem_req  <= 1'b1;
                                mem_addr <= sum_addr;
                                base_q   <= sum_addr;
                                state    <= ST_DL_REQ;
                            end
                            OP_DPOP: begin
                                mem_req   <= 1'b1;
                                mem_we    <= 1'b1;
                                mem_addr  <= sum_addr;
                                mem_wdata <= rd_next;
                                base_q    <= sum_addr;
                                state     <= ST_DP_HI;
                            end
                            OP_IDXRD: begin
                                mem_req  <= 1'b1;
                                mem_addr <= ADDR_W'(rd_top + cmd_data);
                                state    <= ST_IX_REQ;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_DL_REQ: begin
                    mem_req  <= 1'b1;
                    mem_addr <= base_q + ADDR_W'(1);
                    state    <= ST_DL_LO;
                end
                ST_DL_LO: begin
                    sp    <= sp + PTR_W'(1);
                    state <= ST_DL_HI;
                end
                ST_DL_HI: begin
                    sp    <= sp + PTR_W'(1);
                    state <= ST_IDLE;
                end
                ST_DP_HI: begin
                    mem_req   <= 1'b1;
                    mem_we    <= 1'b1;
                    mem_addr  <= base_q + ADDR_W'(1);
                    mem_wdata <= rd_top;
                    sp        <= sp - PTR_W'(2);
                    state     <= ST_IDLE;
                end
                ST_IX_REQ: state <= ST_IX_CAP;
                ST_IX_CAP: begin
                    sp    <= sp + PTR_W'(1);
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eval_stack.sv
// Top of the evaluation stack: joins the cell array, the bounds check and
// the sequencer. Assumes a one-cycle-latency word memory on the request port.
module eval_stack #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic [PTR_W-1:0]  depth,
    output logic [DATA_W-1:0] top_data,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [1:0]        trap_code,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import estk_pkg::*;

    op_e               op;
    trap_e             trap_c;
    trap_e             trap_q;
    logic [PTR_W-1:0]  sp;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_widx;
    logic [DATA_W-1:0] rf_wdata;
    logic [IDX_W-1:0]  ridx_top;
    logic [IDX_W-1:0]  ridx_next;
    logic [DATA_W-1:0] rd_top;
    logic [DATA_W-1:0] rd_next;

    // Port-level views of internal state.
    always_comb begin
        op        = op_e'(cmd_op);
        depth     = sp;
        top_data  = (sp == '0) ? '0 : rd_top;
        trap_code = trap_q;
    end

    estk_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_cells (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
        .ridx_top(ridx_top), .ridx_next(ridx_next), .rd_top(rd_top), .rd_next(rd_next)
    );

    estk_guard #(.DEPTH(DEPTH)) i_guard (
        .op(op), .sp(sp), .trap(trap_c)
    );

    estk_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op),
        .cmd_data(cmd_data), .cmd_addr(cmd_addr), .trap_c(trap_c),
        .rd_top(rd_top), .rd_next(rd_next), .mem_rdata(mem_rdata),
        .sp(sp), .busy(busy), .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .ridx_top(ridx_top), .ridx_next(ridx_next), .pop_data(pop_data),
        .pop_valid(pop_valid), .trap_q(trap_q), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/eval_stack_chk.sv
// Cycle-level checks on the stack's ports, attached to every eval_stack
// instance by the bind below.
module eval_stack_chk #(
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] depth,
    input logic [1:0]       trap_code,
    input logic             busy,
    input logic             pop_valid
);
    assert_depth_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= PTR_W'(DEPTH));

    assert_trap_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_code != 2'd3);

    assert_trap_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_code != 2'd0) |-> depth == $past(depth));

    assert_trap_not_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_code != 2'd0) |-> !busy);

    assert_pop_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> depth == $past(depth) - PTR_W'(1));
endmodule

bind eval_stack eval_stack_chk #(.DEPTH(DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .depth(depth), .trap_code(trap_code),
    .busy(busy), .pop_valid(pop_valid)
);

// File: tb/test_eval_stack.sv
// Directed bench for eval_stack: one task per scenario, each checking its
// own results; includes a one-cycle-latency memory model.
module test_eval_stack;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_data = '0;
    logic [15:0] cmd_addr = '0;
    logic        busy;
    logic [3:0]  depth;
    logic [15:0] top_data;
    logic [15:0] pop_data;
    logic        pop_valid;
    logic [1:0]  trap_code;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [15:0] mem [256];

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    eval_stack i_eval_stack (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_addr(cmd_addr), .busy(busy), .depth(depth),
        .top_data(top_data), .pop_data(pop_data), .pop_valid(pop_valid),
        .trap_code(trap_code), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: word k resets to A000+k; reads return one cycle later.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'hA000 + 16'(i);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one command for one rising edge; returns at the next falling edge.
    task automatic issue(input logic [2:0] op, input logic [15:0] d, input logic [15:0] a);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0;
    endtask

    task automatic t_reset;
        check("R1 depth", 32'(depth), 0);
        check("R1 top", 32'(top_data), 0);
        check("R1 trap", 32'(trap_code), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_push_pop;
        issue(3'd1, 16'h1111, 0);
        issue(3'd1, 16'h2222, 0);
        issue(3'd1, 16'h3333, 0);
        check("R2 depth", 32'(depth), 3);
        check("R2 top", 32'(top_data), 32'h3333);
        issue(3'd2, 0, 0);
        check("R4 pop_valid", 32'(pop_valid), 1);
        check("R4 pop_data", 32'(pop_data), 32'h3333);
        check("R4 depth", 32'(depth), 2);
        check("R2 lifo top", 32'(top_data), 32'h2222);
        @(negedge clk);
        check("R4 strobe ends", 32'(pop_valid), 0);
    endtask

    task automatic t_underflow;
        issue(3'd2, 0, 0);
        issue(3'd2, 0, 0);
        check("R2 last pop", 32'(pop_data), 32'h1111);
        issue(3'd2, 0, 0);
        check("R5 pop trap", 32'(trap_code), 2);
        check("R5 pop depth", 32'(depth), 0);
        check("R5 no strobe", 32'(pop_valid), 0);
        @(negedge clk);
        check("R12 pulse ends", 32'(trap_code), 0);
        issue(3'd3, 0, 16'h0010);
        check("R5 store trap", 32'(trap_code), 2);
        check("R5 store no write", 32'(mem_req), 0);
        issue(3'd6, 0, 0);
        check("R11 idx underflow", 32'(trap_code), 2);
        issue(3'd5, 0, 16'h0030);
        check("R10 dpop empty", 32'(trap_code), 2);
        issue(3'd1, 16'h4444, 0);
        issue(3'd5, 0, 16'h0030);
        check("R10 dpop one", 32'(trap_code), 2);
        check("R10 depth held", 32'(depth), 1);
        check("R10 top held", 32'(top_data), 32'h4444);
        issue(3'd2, 0, 0);
    endtask

    task automatic t_store;
        issue(3'd1, 16'hBEEF, 0);
        issue(3'd3, 0, 16'h0020);
        check("R6 depth", 32'(depth), 0);
        check("R6 req", 32'({mem_req, mem_we}), 3);
        @(negedge clk);
        check("R6 mem", 32'(mem[8'h20]), 32'hBEEF);
    endtask

    task automatic t_dpush;
        issue(3'd4, 16'h0002, 16'h003E);
        check("R7 busy", 32'(busy), 1);
        issue(3'd1, 16'h7777, 0);
        @(negedge clk);
        @(negedge clk);
        check("R7 depth", 32'(depth), 2);
        check("R13 busy done", 32'(busy), 0);
        check("R7 top high", 32'(top_data), 32'hA041);
        issue(3'd2, 0, 0);
        check("R7 high popped", 32'(pop_data), 32'hA041);
        issue(3'd2, 0, 0);
        check("R7 low popped", 32'(pop_data), 32'hA040);
        check("R13 push ignored", 32'(depth), 0);
    endtask

    task automatic t_overflow;
        for (int k = 0; k < 7; k++) issue(3'd1, 16'h0100 + 16'(k), 0);
        issue(3'd4, 0, 16'h0040);
        check("R8 trap", 32'(trap_code), 1);
        check("R8 no req", 32'(mem_req), 0);
        check("R8 depth", 32'(depth), 7);
        check("R8 idle", 32'(busy), 0);
        issue(3'd1, 16'h0107, 0);
        check("R2 full depth", 32'(depth), 8);
        issue(3'd1, 16'hDEAD, 0);
        check("R3 trap", 32'(trap_code), 1);
        check("R3 depth", 32'(depth), 8);
        check("R3 top", 32'(top_data), 32'h0107);
        issue(3'd6, 0, 0);
        check("R11 idx overflow", 32'(trap_code), 1);
    endtask

    task automatic t_dpop;
        issue(3'd5, 16'h0003, 16'h0050);
        check("R9 low write", 32'({mem_req, mem_we, mem_addr}), 32'h3_0053);
        @(negedge clk);
        check("R9 low first", 32'(mem[8'h53]), 32'h0106);
        check("R9 high later", 32'(mem[8'h54]), 32'hA054);
        check("R9 depth", 32'(depth), 6);
        @(negedge clk);
        check("R9 high", 32'(mem[8'h54]), 32'h0107);
        check("R9 top", 32'(top_data), 32'h0105);
    endtask

    task automatic t_idx;
        issue(3'd6, 16'h0010, 0);
        check("R11 busy", 32'(busy), 1);
        check("R11 addr", 32'(mem_addr), 32'h0115);
        @(negedge clk);
        @(negedge clk);
        check("R11 depth", 32'(depth), 7);
        check("R11 data", 32'(top_data), 32'hA015);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_underflow();
        t_store();
        t_dpush();
        t_overflow();
        t_dpop();
        t_idx();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule